// File: doc/BRIEF.md
# Triplexed LCD segment driver

This block is the digital core of a one-third-duty liquid-crystal display driver. A host loads a complete display image over a three-wire serial link made of a chip enable, a shift clock and a data line. The block keeps the image in a display latch. From a free-running oscillator tick it produces three common waveforms and 68 segment waveforms. Each output is a 2-bit code that stands for one of four drive voltages; the analog bias network and the pads that turn these codes into voltages sit outside the block.

A frame lasts 384 oscillator ticks and is split evenly across the three commons. The drive polarity flips on every frame, so the average voltage across each pixel is zero. The first four segment pins can each be set to act as a static general-purpose output instead of a segment. An active-low inhibit input pulls every output to ground and cancels the port setting. The serial link keeps accepting images while the inhibit is active.

The serial inputs, `osc_tick` and `inh_n` are plain, level-sampled pins that are synchronous to `clk`. The serial link is a fixed three-wire protocol and not a handshaked stream: the host paces it and the block never applies back-pressure.

Top module: `lcd3_driver`

## Requirements
- R1: Each `osc_tick` pulse advances the frame by one step. Common 0 is selected for ticks 0–127 of a frame, common 1 for ticks 128–255, and common 2 for ticks 256–383, after which the next frame begins. With no tick, the frame position does not move.
- R2: Polarity starts at 0 after reset and toggles at every frame boundary. Level codes are 0 = ground, 1 = one-third, 2 = two-thirds, 3 = supply. In polarity 0 the selected common drives 3 and the other commons drive 1. In polarity 1 the selected common drives 0 and the other commons drive 2.
- R3: A segment whose bit is set for the currently selected common drives 0 in polarity 0 and 3 in polarity 1. A segment whose bit is clear drives 2 in polarity 0 and 1 in polarity 1.
- R4: A data frame is 212 bits, and the first bit shifted in is bit 0. Bits 0–203 are display bits: bit s*3+c belongs to segment s (0–67) on common c (0–2). Bits 204–207 are port-mode flags for segments 0–3, where 1 means port. Bits 208–211 are the port values for segments 0–3.
- R5: Bits are sampled on rising edges of the serial clock. While chip enable is low, the bits go into an 8-bit address register, least significant bit first. While chip enable is high, the bits go into the data register. Chip enable then falls. The data is latched on that fall only if two conditions hold: the address held when chip enable rose was 0x42, and exactly 212 bits were shifted while chip enable was high. Any other transfer is discarded and leaves all outputs unchanged.
- R6: A segment 0–3 in port mode drives 3 when its port value is 1 and 0 when its port value is 0, at every point of every frame.
- R7: While `inh_n` is 0, every common and segment output is 0, including segments in port mode.
- R8: A valid transfer completed while `inh_n` is 0 is latched, and it is shown as soon as `inh_n` returns to 1.
- R9: After reset, every output is 0 until the first valid transfer is latched, and all four port-mode flags select segment function.
- R10: While a transfer is still being shifted in, the outputs keep showing the previously latched image.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator clock |
| inh_n | input | 1 | Display inhibit, active low |
| ser_ce | input | 1 | Serial chip enable |
| ser_cl | input | 1 | Serial shift clock |
| ser_di | input | 1 | Serial data |
| com_lvl | output | 6 | Common level codes, 2 bits per common, common 0 in bits 1:0 |
| seg_lvl | output | 136 | Segment level codes, 2 bits per segment, segment 0 in bits 1:0 |

## Verification
Two states are hard to reach from the ports: an image held back while it is still being shifted in, and an image latched while the display is inhibited. To reach the first, the bench stops partway through a transfer and compares every output against the old image. It then drops chip enable early, which leaves a short transfer that must be discarded. To reach the second, it holds `inh_n` low, loads a new image together with port settings, checks that every output stays at ground, and releases the inhibit. The frame sequence is swept over two complete frames, one tick at a time, and every output is checked against arithmetic expectations at each step. The bench also steps through all sixteen port-mode combinations.

// File: rtl/lcd3_pkg.sv
package lcd3_pkg;
  typedef enum logic [1:0] {
    LV_GND       = 2'd0,
    LV_THIRD     = 2'd1,
    LV_TWO_THIRD = 2'd2,
    LV_SUPPLY    = 2'd3
  } lvl_e;

  // Level driven by a common, given whether it is selected and the frame polarity
  function automatic lvl_e com_level(input logic sel, input logic pol);
    if (sel) return pol ? LV_GND : LV_SUPPLY;
    return pol ? LV_TWO_THIRD : LV_THIRD;
  endfunction

  // Level driven by a segment, given its display bit and the frame polarity
  function automatic lvl_e seg_level(input logic on, input logic pol);
    if (on) return pol ? LV_SUPPLY : LV_GND;
    return pol ? LV_THIRD : LV_TWO_THIRD;
  endfunction
endpackage

// File: rtl/lcd3_serial_rx.sv
module lcd3_serial_rx #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] ADDR_VAL = 8'h42,
  parameter int                DATA_W   = 212
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              cl,
  input  logic              di,
  output logic              load_vld,
  output logic [DATA_W-1:0] load_data
);
  localparam int CW = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] CNT_SAT  = CW'(DATA_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DATA_W);

  logic              ce_q, cl_q, addr_ok;
  logic [ADDR_W-1:0] addr_sh;
  logic [DATA_W-1:0] data_sh;
  logic [CW-1:0]     cnt;
  logic              cl_rise, ce_rise, ce_fall;

  assign cl_rise = cl & ~cl_q;
  assign ce_rise = ce & ~ce_q;
  assign ce_fall = ~ce & ce_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q      <= 1'b0;
      cl_q      <= 1'b0;
      addr_ok   <= 1'b0;
      addr_sh   <= '0;
      data_sh   <= '0;
      cnt       <= '0;
      load_vld  <= 1'b0;
      load_data <= '0;
    end else begin
      ce_q     <= ce;
      cl_q     <= cl;
      load_vld <= 1'b0;
      if (cl_rise) begin
        if (ce) begin
          data_sh <= {di, data_sh[DATA_W-1:1]};
          if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end else begin
          addr_sh <= {di, addr_sh[ADDR_W-1:1]};
        end
      end
      if (ce_rise) begin
        cnt     <= '0;
        addr_ok <= (addr_sh == ADDR_VAL);
      end
      if (ce_fall) begin
        if (addr_ok && cnt == CNT_FULL) begin
          load_vld  <= 1'b1;
          load_data <= data_sh;
        end
        addr_ok <= 1'b0;
      end
    end
  end

  // R5
  load_on_ce_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_vld |-> (!ce_q && $past(ce_q)));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_SAT);
endmodule

// File: rtl/lcd3_timing.sv
module lcd3_timing #(
  parameter int NCOM  = 3,
  parameter int FRAME = 384,
  localparam int CIW  = (NCOM > 1) ? $clog2(NCOM) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  output logic [CIW-1:0] com_idx,
  output logic           pol
);
  localparam int SLOT = FRAME / NCOM;
  localparam int PW   = (SLOT > 1) ? $clog2(SLOT) : 1;
  localparam logic [PW-1:0]  PH_LAST  = PW'(SLOT - 1);
  localparam logic [CIW-1:0] COM_LAST = CIW'(NCOM - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      com_idx <= '0;
      pol     <= 1'b0;
    end else if (tick) begin
      if (phase == PH_LAST) begin
        phase <= '0;
        if (com_idx == COM_LAST) begin
          com_idx <= '0;
          pol     <= ~pol;
        end else begin
          com_idx <= com_idx + 1'b1;
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  // R1
  com_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    com_idx <= COM_LAST);

  // R1
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(com_idx) && $stable(phase) && $stable(pol)));

  // R2
  pol_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && com_idx == COM_LAST && phase == PH_LAST) |=> (pol != $past(pol)));
endmodule

// File: rtl/lcd3_drive.sv
module lcd3_drive
  import lcd3_pkg::*;
#(
  parameter int NCOM  = 3,
  parameter int NSEG  = 68,
  parameter int NPORT = 4,
  localparam int CIW  = (NCOM > 1) ? $clog2(NCOM) : 1
) (
  input  logic [CIW-1:0]       com_idx,
  input  logic                 pol,
  input  logic                 blank,
  input  logic [NSEG*NCOM-1:0] disp,
  input  logic [NPORT-1:0]     pmode,
  input  logic [NPORT-1:0]     pval,
  output logic [NCOM*2-1:0]    com_lvl,
  output logic [NSEG*2-1:0]    seg_lvl
);
  for (genvar c = 0; c < NCOM; c++) begin : g_com
    always_comb begin
      if (blank) com_lvl[c*2 +: 2] = LV_GND;
      else       com_lvl[c*2 +: 2] = com_level(com_idx == CIW'(c), pol);
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic on;
    assign on = disp[s*NCOM + int'(com_idx)];
    if (s < NPORT) begin : g_port
      always_comb begin
        if (blank)         seg_lvl[s*2 +: 2] = LV_GND;
        else if (pmode[s]) seg_lvl[s*2 +: 2] = pval[s] ? LV_SUPPLY : LV_GND;
        else               seg_lvl[s*2 +: 2] = seg_level(on, pol);
      end
    end else begin : g_plain
      always_comb begin
        if (blank) seg_lvl[s*2 +: 2] = LV_GND;
        else       seg_lvl[s*2 +: 2] = seg_level(on, pol);
      end
    end
  end
endmodule

// File: rtl/lcd3_driver.sv
module lcd3_driver #(
  parameter int         NCOM   = 3,
  parameter int         NSEG   = 68,
  parameter int         NPORT  = 4,
  parameter int         FRAME  = 384,
  parameter int         ADDR_W = 8,
  parameter logic [7:0] ADDR   = 8'h42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              inh_n,
  input  logic              ser_ce,
  input  logic              ser_cl,
  input  logic              ser_di,
  output logic [NCOM*2-1:0] com_lvl,
  output logic [NSEG*2-1:0] seg_lvl
);
  localparam int DISP_W = NSEG * NCOM;
  localparam int DATA_W = DISP_W + 2 * NPORT;
  localparam int CIW    = (NCOM > 1) ? $clog2(NCOM) : 1;

  logic              load_vld;
  logic [DATA_W-1:0] load_data;
  logic [DISP_W-1:0] disp_q;
  logic [NPORT-1:0]  pmode_q, pval_q;
  logic              shown_q, blank;
  logic [CIW-1:0]    com_idx;
  logic              pol;

  lcd3_serial_rx #(.ADDR_W(ADDR_W), .ADDR_VAL(ADDR_W'(ADDR)), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .ce(ser_ce), .cl(ser_cl), .di(ser_di),
    .load_vld(load_vld), .load_data(load_data)
  );

  lcd3_timing #(.NCOM(NCOM), .FRAME(FRAME)) u_tim (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .com_idx(com_idx), .pol(pol)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q  <= '0;
      pmode_q <= '0;
      pval_q  <= '0;
      shown_q <= 1'b0;
    end else if (load_vld) begin
      disp_q  <= load_data[DISP_W-1:0];
      pmode_q <= load_data[DISP_W +: NPORT];
      pval_q  <= load_data[DISP_W+NPORT +: NPORT];
      shown_q <= 1'b1;
    end
  end

  assign blank = ~inh_n | ~shown_q;

  lcd3_drive #(.NCOM(NCOM), .NSEG(NSEG), .NPORT(NPORT)) u_drv (
    .com_idx(com_idx), .pol(pol), .blank(blank), .disp(disp_q),
    .pmode(pmode_q), .pval(pval_q), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // Commons sitting at an extreme level (selected)
  logic [NCOM-1:0] com_ext;
  always_comb begin
    for (int c = 0; c < NCOM; c++)
      com_ext[c] = (com_lvl[c*2 +: 2] == 2'd0) || (com_lvl[c*2 +: 2] == 2'd3);
  end

  // R2
  one_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |-> $onehot(com_ext));

  // R7
  inhibit_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inh_n |-> (com_lvl == '0 && seg_lvl == '0));

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_vld |=> ($stable(disp_q) && $stable(pmode_q) && $stable(pval_q)));

  // R6
  port_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && pmode_q[0]) |-> (seg_lvl[1:0] == {2{pval_q[0]}}));

  // R9
  reset_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shown_q |-> (com_lvl == '0 && seg_lvl == '0));
endmodule

// File: tb/lcd3_driver_tb.sv
module lcd3_driver_tb;
  localparam int NSEG = 68, NCOM = 3, DW = 212;

  logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0, inh_n = 1'b1;
  logic ser_ce = 1'b0, ser_cl = 1'b0, ser_di = 1'b0;
  logic [NCOM*2-1:0] com_lvl;
  logic [NSEG*2-1:0] seg_lvl;

  int n_tests = 0, n_fail = 0, ticks = 0;
  logic [203:0] m_disp = '0;
  logic [3:0]   m_pm = '0, m_pv = '0;
  logic         m_shown = 1'b0;

  always #2 clk = ~clk;

  lcd3_driver u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .inh_n(inh_n),
    .ser_ce(ser_ce), .ser_cl(ser_cl), .ser_di(ser_di),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int  com   = (ticks / 128) % 3;
    int  pol   = (ticks / 384) % 2;
    bit  blank = !inh_n || !m_shown;
    for (int c = 0; c < NCOM; c++) begin
      int e = blank ? 0 : (c == com) ? (pol ? 0 : 3) : (pol ? 2 : 1);
      chk(tag, $sformatf("com%0d", c), int'(com_lvl[c*2 +: 2]), e);
    end
    for (int s = 0; s < NSEG; s++) begin
      int e;
      if (blank)                e = 0;
      else if (s < 4 && m_pm[s]) e = m_pv[s] ? 3 : 0;
      else if (m_disp[s*3+com])  e = pol ? 3 : 0;
      else                       e = pol ? 1 : 2;
      chk(tag, $sformatf("seg%0d", s), int'(seg_lvl[s*2 +: 2]), e);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) osc_tick = 1'b1;
      @(negedge clk) osc_tick = 1'b0;
      ticks++;
    end
  endtask

  task automatic ser_bit(input logic b);
    @(negedge clk) ser_di = b;
    @(negedge clk) ser_cl = 1'b1;
    @(negedge clk) ser_cl = 1'b0;
  endtask

  // Sends address then n data bits; optional mid-transfer check after stop_at bits
  task automatic send(input logic [7:0] a, input logic [DW-1:0] f, input int n,
                      input int stop_at);
    @(negedge clk) ser_ce = 1'b0;
    for (int i = 0; i < 8; i++) ser_bit(a[i]);
    @(negedge clk) ser_ce = 1'b1;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      ser_bit(i < DW ? f[i] : 1'b1);
      if (i + 1 == stop_at) begin
        @(negedge clk);
        check_all("R10");
      end
    end
    @(negedge clk) ser_ce = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [203:0] pattern(input int seed);
    logic [203:0] p;
    for (int i = 0; i < 204; i++) p[i] = ((i * seed + 3) % 7) < 3;
    return p;
  endfunction

  task automatic load(input logic [203:0] d, input logic [3:0] pm, input logic [3:0] pv);
    send(8'h42, {pv, pm, d}, DW, -1);
    m_disp = d; m_pm = pm; m_pv = pv; m_shown = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: dark after reset, even as the frame runs
    check_all("R9");
    tick(130);
    check_all("R9");
    // R4, R3: first image, then two full frames swept tick by tick (R1, R2)
    load(pattern(5), 4'h0, 4'h0);
    check_all("R4");
    for (int t = 0; t < 768; t++) begin
      tick(1);
      check_all("R1_R2_R3");
    end
    // R3: all on and all off images across both polarities
    load('1, 4'h0, 4'h0);
    check_all("R3");
    tick(384);
    check_all("R3");
    load('0, 4'h0, 4'h0);
    check_all("R3");
    tick(200);
    check_all("R3");
    load(pattern(11), 4'h0, 4'h0);
    // R5: wrong address, short and long transfers are discarded
    send(8'h43, {4'hF, 4'hF, pattern(3)}, DW, -1);
    check_all("R5");
    send(8'h42, {4'hF, 4'hF, pattern(3)}, DW - 1, -1);
    check_all("R5");
    send(8'h42, {4'hF, 4'hF, pattern(3)}, DW + 1, -1);
    check_all("R5");
    // R10: outputs unchanged in mid-transfer; the cut transfer is discarded
    send(8'h42, {4'hF, 4'hF, pattern(2)}, 100, 100);
    check_all("R10");
    // R6: every port-mode combination across commons and polarities
    for (int m = 0; m < 16; m++) begin
      load(pattern(m + 1), 4'(m), 4'(m * 5 + 6));
      check_all("R6");
      tick(150);
      check_all("R6");
      tick(250);
      check_all("R6");
    end
    // R7: inhibit blanks everything, including ports
    @(negedge clk) inh_n = 1'b0;
    @(negedge clk);
    check_all("R7");
    tick(129);
    check_all("R7");
    // R8: load during inhibit, then release
    load(pattern(9), 4'b0110, 4'b0100);
    check_all("R8");
    @(negedge clk) inh_n = 1'b1;
    @(negedge clk);
    check_all("R8");
    tick(300);
    check_all("R8");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule